// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight edge-triggered interrupt inputs and raises a single interrupt line toward a processor. Software reaches it through a two-address register port. Address 0 is the command port and address 1 is the data port. Before the block does anything, software must write a short initialization sequence. That sequence sets the vector base, the cascade arrangement and the end-of-interrupt style. Once the sequence is done, data-port writes load the mask. Command-port writes choose which status register a command-port read returns, and they retire in-service levels.

Priority is fixed, with input 0 the most urgent. A pending, unmasked request interrupts only when it outranks every level already in service. The processor answers the interrupt with a one-cycle acknowledge strobe. The block then presents a vector equal to the base plus the level number and moves that level from pending to in-service. If a request disappears before the acknowledge arrives, the block delivers the level-7 vector and leaves the in-service register untouched, so that software can recognise the event as spurious. When an acknowledged input has a subordinate controller attached, the block also reports that input's number on a cascade code output.

Top module: `prio_intc`

## Requirements
- R1: After reset the request and in-service registers are 0, the mask reads 0xFF, the interrupt output is low, the vector output is 0 and the block is uninitialized.
- R2: A command write with bit 4 set starts initialization. It clears the request and in-service registers, selects the request register for reads and clears the cascade word and the auto-EOI flag. The data writes that follow are taken in order: the vector base first, then the cascade word (skipped when bit 1 of the start word is set, single mode), then the mode word (present only when bit 0 of the start word is set). The block becomes ready after the last expected word. The mask keeps its value through initialization.
- R3: When the block is ready, a data write loads the 8-bit mask and a data read returns it. A masked request is latched but never raises the interrupt.
- R4: When the block is ready, a command write of 0x0A makes command reads return the request register and 0x0B makes them return the in-service register (bit n is level n). The request register is the default.
- R5: When the block is ready, a rising edge on input n sets request bit n. The bit clears when the input goes low or when level n is acknowledged.
- R6: Priority is fixed, with level 0 highest. The interrupt output is high exactly when the highest-priority unmasked pending level is above every in-service level.
- R7: An acknowledge while a level n is eligible sets the vector output to base + n at that clock edge, clears request bit n and sets in-service bit n.
- R8: When the block is ready, a command write of 0x60 + n clears in-service bit n only.
- R9: When bit 1 of the mode word is set (auto-EOI), an acknowledge does not set the in-service bit.
- R10: An acknowledge while no level is eligible delivers the vector base + 7 and leaves the in-service register unchanged.
- R11: In the cycle after an acknowledge of level n whose cascade-word bit n is set, and only when not in single mode, the cascade-active output is high and the cascade code equals n. Otherwise the cascade-active output is low.
- R12: While uninitialized or mid-sequence, requests are not latched, the interrupt output stays low and acknowledges have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the addressed port (combinational) |
| irq_in | input | 8 | Interrupt request inputs, bit n = level n |
| int_out | output | 1 | Interrupt toward the processor |
| ack | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Vector from the most recent acknowledge |
| cas_act | output | 1 | Acknowledged level drives a subordinate controller |
| cas_code | output | 3 | Level number of that cascaded input |

## Verification
The hardest case to reach is the spurious delivery. A request must be latched and must raise the interrupt, and then the input has to fall back low in the cycle before the acknowledge is sampled, so that the request bit is gone when the strobe arrives. The stimulus raises an input, waits one cycle until the interrupt is visible, drops the input and pulses the acknowledge on the next cycle. This is done with level 7 masked, to show that the mask does not hide the spurious vector. A behavioural model built on integers is compared with the outputs on every cycle. It follows nested in-service levels, cascade hits, auto-EOI and a re-initialization into single mode.

// File: rtl/intc_pkg.sv
// Shared constants and types for the priority interrupt controller.
// Assumes an 8-bit register bus; the level count may shrink, not grow past 8.
package intc_pkg;
    parameter int NLVL = 8;
    parameter int BUSW = 8;
    localparam int LVLW = $clog2(NLVL);

    // Initialization sequencer position
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BASE = 2'd1,
        SEQ_CASC = 2'd2,
        SEQ_MODE = 2'd3
    } seq_t;

    // Settings captured by the initialization sequence
    typedef struct packed {
        logic [BUSW-1:0] base;
        logic [BUSW-1:0] casc;
        logic            single;
        logic            aeoi;
    } cfg_t;

    // Command codes written to the command port
    localparam logic [BUSW-1:0] CMD_SEL_REQ = 8'h0A;
    localparam logic [BUSW-1:0] CMD_SEL_ISV = 8'h0B;
    localparam logic [4:0]      CMD_EOI_TOP = 5'b01100;
endpackage

// File: rtl/intc_cfg.sv
// Register-port front end: runs the initialization sequence, holds the
// mask and the read-select, and decodes specific end-of-interrupt commands.
// Assumes single-cycle write strobes; decoded pulses are valid in the
// write cycle and are consumed at the same clock edge by the tracker.
module intc_cfg
    import intc_pkg::*;
#(
    parameter int N  = NLVL,
    parameter int DW = BUSW,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output cfg_t          cfg,
    output logic [N-1:0]  mask,
    output logic          ready,
    output logic          init_clr,
    output logic          rd_isv,
    output logic          eoi_valid,
    output logic [LW-1:0] eoi_lvl
);
    logic cmd_wr, dat_wr;
    seq_t seq_q;
    logic need_casc_q, need_mode_q;

    assign cmd_wr    = wr_en && !addr;
    assign dat_wr    = wr_en && addr;
    assign init_clr  = cmd_wr && wdata[4];
    assign eoi_valid = cmd_wr && ready && (wdata[7:3] == CMD_EOI_TOP);
    assign eoi_lvl   = wdata[LW-1:0];

    // Walks the start word and the data words that follow it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q       <= SEQ_IDLE;
            ready       <= 1'b0;
            cfg         <= '0;
            need_casc_q <= 1'b0;
            need_mode_q <= 1'b0;
        end else if (init_clr) begin
            seq_q       <= SEQ_BASE;
            ready       <= 1'b0;
            need_casc_q <= !wdata[1];
            need_mode_q <= wdata[0];
            cfg.single  <= wdata[1];
            cfg.aeoi    <= 1'b0;
            cfg.casc    <= '0;
        end else if (dat_wr) begin
            case (seq_q)
                SEQ_BASE: begin
                    cfg.base <= wdata;
                    if (need_casc_q) begin
                        seq_q <= SEQ_CASC;
                    end else if (need_mode_q) begin
                        seq_q <= SEQ_MODE;
                    end else begin
                        seq_q <= SEQ_IDLE;
                        ready <= 1'b1;
                    end
                end
                SEQ_CASC: begin
                    cfg.casc <= wdata;
                    if (need_mode_q) begin
                        seq_q <= SEQ_MODE;
                    end else begin
                        seq_q <= SEQ_IDLE;
                        ready <= 1'b1;
                    end
                end
                SEQ_MODE: begin
                    cfg.aeoi <= wdata[1];
                    seq_q    <= SEQ_IDLE;
                    ready    <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Mask register: loaded by data writes once ready
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
        end else if (dat_wr && ready) begin
            mask <= wdata[N-1:0];
        end
    end

    // Read-select: request register by default, switched by command codes
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) begin
            rd_isv <= 1'b0;
        end else if (cmd_wr && ready && wdata == CMD_SEL_REQ) begin
            rd_isv <= 1'b0;
        end else if (cmd_wr && ready && wdata == CMD_SEL_ISV) begin
            rd_isv <= 1'b1;
        end
    end

    // R1
    mask_reset_chk: assert property (@(posedge clk) !rst_n |=> mask == '1);
    // R12
    seq_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |=> !ready);
endmodule

// File: rtl/intc_prio.sv
// Fixed-priority resolver: finds the most urgent unmasked pending level
// that outranks every in-service level. Level 0 is the most urgent.
// Purely combinational; assumes registered inputs.
module intc_prio #(
    parameter int N  = intc_pkg::NLVL,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr,
    input  logic [N-1:0]  isr,
    input  logic [N-1:0]  mask,
    output logic          grant_valid,
    output logic [LW-1:0] grant_lvl
);
    logic [N-1:0] cand;
    logic [N:0]   blocked;

    // Per level: eligible request, and the running in-service block
    assign blocked[0] = 1'b0;
    for (genvar g = 0; g < N; g++) begin : g_lvl
        assign cand[g]      = irr[g] && !mask[g] && !blocked[g] && !isr[g];
        assign blocked[g+1] = blocked[g] || isr[g];
    end

    // Pick the lowest-numbered eligible candidate
    always_comb begin
        grant_valid = 1'b0;
        grant_lvl   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                grant_valid = 1'b1;
                grant_lvl   = LW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_track.sv
// Request and in-service bookkeeping: edge capture of inputs, the
// acknowledge transfer, end-of-interrupt retirement, vector and cascade
// outputs. Assumes the acknowledge is a single-cycle strobe.
module intc_track
    import intc_pkg::*;
#(
    parameter int N  = NLVL,
    parameter int DW = BUSW,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_in,
    input  logic          ready,
    input  logic          init_clr,
    input  logic          eoi_valid,
    input  logic [LW-1:0] eoi_lvl,
    input  logic          ack,
    input  logic          grant_valid,
    input  logic [LW-1:0] grant_lvl,
    input  cfg_t          cfg,
    output logic [N-1:0]  irr,
    output logic [N-1:0]  isr,
    output logic [DW-1:0] vec_out,
    output logic          cas_act,
    output logic [LW-1:0] cas_code
);
    localparam logic [N-1:0]  ONE   = N'(1);
    localparam logic [DW-1:0] LASTV = DW'(N - 1);

    logic [N-1:0] prev_q, rise, ack_clr, isv_set, eoi_clr;
    logic         take;

    assign rise    = irq_in & ~prev_q;
    assign take    = ack && ready && grant_valid;
    assign ack_clr = take ? (ONE << grant_lvl) : '0;
    assign isv_set = (take && !cfg.aeoi) ? (ONE << grant_lvl) : '0;
    assign eoi_clr = eoi_valid ? (ONE << eoi_lvl) : '0;

    // Previous input sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= irq_in;
    end

    // Request register: set on rising edge, dropped with the input or at ack
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr || !ready) irr <= '0;
        else irr <= ((irr & ~ack_clr) | rise) & irq_in;
    end

    // In-service register: set at ack unless auto-EOI, cleared by EOI
    always_ff @(posedge clk) begin
        if (!rst_n || init_clr) isr <= '0;
        else isr <= (isr & ~eoi_clr) | isv_set;
    end

    // Vector output: granted level or the spurious last level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_out <= '0;
        end else if (ack && ready) begin
            vec_out <= take ? (cfg.base + DW'(grant_lvl)) : (cfg.base + LASTV);
        end
    end

    // Cascade report for acknowledged inputs that feed a subordinate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_act  <= 1'b0;
            cas_code <= '0;
        end else begin
            cas_act <= take && !cfg.single && cfg.casc[grant_lvl];
            if (take) cas_code <= grant_lvl;
        end
    end

    // R7
    ack_isv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !cfg.aeoi) |=> isr[$past(grant_lvl)] && !irr[$past(grant_lvl)]);
    // R10
    spurious_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && ready && !grant_valid && !init_clr && !eoi_valid)
            |=> (vec_out == $past(cfg.base) + LASTV) && isr == $past(isr));
    // R8
    eoi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !(take && grant_lvl == eoi_lvl)) |=> !isr[$past(eoi_lvl)]);
    // R11
    cas_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cas_act |-> $past(ack));
endmodule

// File: rtl/prio_intc.sv
// Top of the eight-level priority interrupt controller: joins the register
// front end, the request tracker and the priority resolver, and muxes the
// read data. Reads are combinational on the address.
module prio_intc
    import intc_pkg::*;
#(
    parameter int N  = NLVL,
    parameter int DW = BUSW,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N-1:0]  irq_in,
    output logic          int_out,
    input  logic          ack,
    output logic [DW-1:0] vec_out,
    output logic          cas_act,
    output logic [LW-1:0] cas_code
);
    cfg_t          cfg;
    logic [N-1:0]  mask, irr, isr;
    logic          ready, init_clr, rd_isv, eoi_valid, grant_valid;
    logic [LW-1:0] eoi_lvl, grant_lvl;

    intc_cfg #(.N(N), .DW(DW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .cfg(cfg), .mask(mask), .ready(ready), .init_clr(init_clr),
        .rd_isv(rd_isv), .eoi_valid(eoi_valid), .eoi_lvl(eoi_lvl)
    );

    intc_prio #(.N(N)) u_prio (
        .irr(irr), .isr(isr), .mask(mask),
        .grant_valid(grant_valid), .grant_lvl(grant_lvl)
    );

    intc_track #(.N(N), .DW(DW)) u_track (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ready(ready),
        .init_clr(init_clr), .eoi_valid(eoi_valid), .eoi_lvl(eoi_lvl),
        .ack(ack), .grant_valid(grant_valid), .grant_lvl(grant_lvl),
        .cfg(cfg), .irr(irr), .isr(isr), .vec_out(vec_out),
        .cas_act(cas_act), .cas_code(cas_code)
    );

    // Read mux: data port returns the mask, command port the selected status
    always_comb begin
        if (addr) rdata = DW'(mask);
        else      rdata = rd_isv ? DW'(isr) : DW'(irr);
    end

    assign int_out = ready && grant_valid;

    // R12
    no_int_unready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_out);
    // R6
    above_isv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> ((isr & ((N'(1) << grant_lvl) | ((N'(1) << grant_lvl) - N'(1)))) == '0));
    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> !mask[grant_lvl] && irr[grant_lvl]);
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0, wr_en = 1'b0, addr = 1'b0, ack = 1'b0;
    logic [7:0] wdata = 8'h00, irq_in = 8'h00;
    logic [7:0] rdata, vec_out;
    logic       int_out, cas_act;
    logic [2:0] cas_code;

    prio_intc uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .ack(ack),
        .vec_out(vec_out), .cas_act(cas_act), .cas_code(cas_code)
    );

    int total = 0, bad = 0;
    bit done = 0;

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit   m_started = 0, m_ready = 0, m_single = 0, m_aeoi = 0, m_rsel = 0;
    bit   m_need_c = 0, m_need_m = 0, m_casact = 0;
    int   m_step = 0;
    logic [7:0] m_irr = 0, m_isr = 0, m_mask = 8'hFF, m_base = 0, m_casc = 0;
    logic [7:0] m_prev = 0, m_vec = 0;
    int   m_code = 0;

    function automatic int m_grant();
        for (int i = 0; i < 8; i++) begin
            if (m_isr[i]) return -1;
            if (m_irr[i] && !m_mask[i]) return i;
        end
        return -1;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 1; m_ready = 0; m_single = 0; m_aeoi = 0; m_rsel = 0;
            m_step = 0; m_casact = 0; m_irr = 0; m_isr = 0; m_mask = 8'hFF;
            m_base = 0; m_casc = 0; m_prev = 0; m_vec = 0; m_code = 0;
            m_need_c = 0; m_need_m = 0;
        end else begin
            logic [7:0] rise, nirr, nisr;
            bit nready, nrsel;
            int g;
            rise = irq_in & ~m_prev;
            m_prev = irq_in;
            g = m_grant();
            nirr = m_irr; nisr = m_isr; nready = m_ready; nrsel = m_rsel;
            m_casact = 0;
            if (ack && m_ready) begin
                if (g >= 0) begin
                    m_vec = m_base + 8'(g);
                    nirr[g] = 0;
                    if (!m_aeoi) nisr[g] = 1;
                    m_casact = !m_single && m_casc[g];
                    m_code = g;
                end else begin
                    m_vec = m_base + 8'd7;
                end
            end
            if (m_ready) nirr = (nirr | rise) & irq_in;
            else nirr = 0;
            if (wr_en && !addr) begin
                if (wdata[4]) begin
                    nready = 0; m_step = 1; m_need_c = !wdata[1]; m_need_m = wdata[0];
                    m_single = wdata[1]; m_aeoi = 0; m_casc = 0; nrsel = 0;
                    nirr = 0; nisr = 0;
                end else if (m_ready) begin
                    if (wdata == 8'h0A) nrsel = 0;
                    if (wdata == 8'h0B) nrsel = 1;
                    if (wdata[7:3] == 5'b01100 && !(ack && g == int'(wdata[2:0]) && !m_aeoi))
                        nisr[wdata[2:0]] = 0;
                end
            end else if (wr_en && addr) begin
                case (m_step)
                    1: begin m_base = wdata;
                       m_step = m_need_c ? 2 : (m_need_m ? 3 : 0);
                       if (m_step == 0) nready = 1; end
                    2: begin m_casc = wdata; m_step = m_need_m ? 3 : 0;
                       if (m_step == 0) nready = 1; end
                    3: begin m_aeoi = wdata[1]; m_step = 0; nready = 1; end
                    default: if (m_ready) m_mask = wdata;
                endcase
            end
            m_irr = nirr; m_isr = nisr; m_ready = nready; m_rsel = nrsel;
        end
    end

    // Per-cycle comparison of every output against the model
    always @(negedge clk) begin
        #1;
        if (m_started && rst_n && !done) begin
            check("R6 int_out", int_out, (m_ready && m_grant() >= 0) ? 1 : 0);
            check("R7 vec_out", vec_out, m_vec);
            check("R11 cas_act", cas_act, m_casact);
            if (m_casact) check("R11 cas_code", cas_code, m_code);
            check("R4 rdata", rdata, addr ? m_mask : (m_rsel ? m_isr : m_irr));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(bit a, logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0;
    endtask
    task automatic ackp();
        @(negedge clk); ack = 1;
        @(negedge clk); ack = 0;
        #1;
    endtask
    task automatic setirq(logic [7:0] v);
        @(negedge clk); irq_in = v;
    endtask
    task automatic idle(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask
    task automatic peek(bit a, string tag, int exp);
        @(negedge clk); addr = a; #1;
        check(tag, rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R1 int_out after reset", int_out, 0);
        check("R1 vec_out after reset", vec_out, 0);
        peek(1, "R1 mask after reset", 8'hFF);
        peek(0, "R1 request reg after reset", 0);

        // R12: nothing happens before initialization
        setirq(8'h08); idle(2);
        check("R12 int low uninitialized", int_out, 0);
        ackp();
        check("R12 ack ignored", vec_out, 0);
        peek(0, "R12 request not latched", 0);
        setirq(8'h00);

        // R2: full sequence, base 0x20, subordinate on input 2, normal EOI
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        peek(1, "R2 mask kept through init", 8'hFF);
        wr(1, 8'h00);
        peek(1, "R3 mask readback", 8'h00);

        setirq(8'h20); idle(1);
        check("R6 single request raises int", int_out, 1);
        peek(0, "R5 request bit set", 8'h20);
        wr(0, 8'h0B);
        peek(0, "R4 in-service selected", 8'h00);
        ackp();
        check("R7 vector level 5", vec_out, 8'h25);
        check("R7 int drops", int_out, 0);
        peek(0, "R7 in-service bit 5", 8'h20);

        setirq(8'h60); idle(1);
        check("R6 lower level blocked", int_out, 0);
        setirq(8'h64); idle(1);
        check("R6 higher level interrupts", int_out, 1);
        ackp();
        check("R7 vector level 2", vec_out, 8'h22);
        check("R11 cascade active", cas_act, 1);
        check("R11 cascade code", cas_code, 2);
        peek(0, "R7 nested in-service", 8'h24);

        wr(0, 8'h62);
        peek(0, "R8 specific EOI clears one bit", 8'h20);
        check("R8 level 6 still blocked", int_out, 0);
        wr(0, 8'h65);
        peek(0, "R8 in-service empty", 8'h00);
        check("R6 level 6 now eligible", int_out, 1);
        ackp();
        check("R7 vector level 6", vec_out, 8'h26);
        check("R11 no cascade on level 6", cas_act, 0);
        wr(0, 8'h66);
        setirq(8'h00);

        // R10: request vanishes before acknowledge, level 7 masked
        wr(1, 8'h80);
        setirq(8'h10); idle(1);
        check("R10 int raised before drop", int_out, 1);
        setirq(8'h00);
        ackp();
        check("R10 spurious vector", vec_out, 8'h27);
        peek(0, "R10 in-service unchanged", 8'h00);
        wr(0, 8'h0A);
        peek(0, "R5 request cleared by fall", 8'h00);

        // R3: masked request latched but silent
        wr(1, 8'h08);
        setirq(8'h08); idle(1);
        check("R3 masked request silent", int_out, 0);
        peek(0, "R3 masked request latched", 8'h08);
        wr(1, 8'h00); #1;
        check("R3 unmask raises int", int_out, 1);
        ackp();
        check("R7 vector level 3", vec_out, 8'h23);
        wr(0, 8'h63);
        setirq(8'h00);

        // R6: two simultaneous requests
        setirq(8'h12); idle(1);
        ackp();
        check("R6 level 1 wins", vec_out, 8'h21);
        check("R6 level 4 blocked by level 1", int_out, 0);
        wr(0, 8'h61); #1;
        check("R6 level 4 after EOI", int_out, 1);
        ackp();
        check("R7 vector level 4", vec_out, 8'h24);
        wr(0, 8'h64);
        setirq(8'h00);

        // R9: re-initialize with auto-EOI, base 0x40
        wr(0, 8'h11); wr(1, 8'h40); wr(1, 8'h04); wr(1, 8'h03);
        peek(1, "R2 mask kept on re-init", 8'h00);
        setirq(8'h09); idle(1);
        ackp();
        check("R9 vector level 0", vec_out, 8'h40);
        wr(0, 8'h0B);
        peek(0, "R9 auto-EOI leaves in-service clear", 8'h00);
        check("R9 next level still eligible", int_out, 1);
        ackp();
        check("R9 vector level 3", vec_out, 8'h43);
        setirq(8'h00);

        // R2/R11: single mode, base word only
        wr(0, 8'h12); wr(1, 8'h80); wr(1, 8'h01);
        peek(1, "R2 short sequence then mask", 8'h01);
        peek(0, "R2 read select back to request", 8'h00);
        setirq(8'h04); idle(1);
        ackp();
        check("R7 vector base 0x80 level 2", vec_out, 8'h82);
        check("R11 no cascade in single mode", cas_act, 0);
        setirq(8'h00);
        idle(3);
        finish_run();
    end
endmodule